// File: doc/BRIEF.md
# Interrupt Pend and Mask Controller

This block keeps the per-line state of an interrupt controller with up to 64 lines. Every line has four bits: the level last reported by its peripheral, a raw pending bit taken before the enable mask, an enable bit, and a status bit that holds pends seen while the line was enabled. Peripherals pend a line either with a single-cycle pulse request or with level raise and lower events. Software sends indexed enable, disable, clear and re-evaluate commands, plus two whole-vector clears. It can also set or clear a global lock. A CPU wake pulse comes out of the block. Selecting a winner by priority is left to a separate arbiter that reads `status_o`.

A line that is pended while it is disabled stays in the raw pending register. Enabling that line later moves the pend into status and wakes the CPU in the same cycle. While the lock is set, pends are still recorded but the block holds back the wake. When the lock is released with status non-zero, a wake is raised at once. On handler exit, software asks the block to re-evaluate a level line. If the stored level is still high, the line is pended again.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, `level_o`, `pend_o`, `mask_o` and `status_o` are all zero, and `lock_o`, `wake_o` and `err_o` are low.
- R2: A valid pulse request on `hw_pend_idx` sets that line's bit in `pend_o` one cycle later. It sets the line's bit in `status_o` only if the line is enabled.
- R3: Command 1 (enable) sets the line's bit in `mask_o`. If the line's `pend_o` bit is already set, the command also sets its `status_o` bit and raises `wake_o` in the same cycle, unless `lock_o` is high.
- R4: Command 2 (disable) clears only the line's `mask_o` bit. The `pend_o` and `status_o` bits are left as they were.
- R5: Command 3 (clear one) clears the line's bit in both `pend_o` and `status_o`. No bit of `status_o` is ever set while the same bit of `pend_o` is clear.
- R6: Command 5 (clear enabled) zeroes `status_o` and clears the `pend_o` bits of enabled lines. The `pend_o` bits of disabled lines are kept.
- R7: Command 4 (clear all) zeroes both `pend_o` and `status_o`.
- R8: A raise event (`lvl_up`=1) sets `level_o` and pends the line only if the stored level bit was low. A raise while the bit is already high changes nothing and causes no wake.
- R9: A lower event (`lvl_up`=0) clears only the line's `level_o` bit. It does not un-pend the line.
- R10: Command 6 (re-evaluate) pends the line by the R2 rule if its `level_o` bit is high. Otherwise it does nothing. It never raises a wake.
- R11: While `lock_o` is high, pends are still recorded but no wake is raised. A write with `lock_wr`=1 and `lock_val`=0 while `lock_o` is high and `status_o` is non-zero raises `wake_o` in the next cycle.
- R12: A valid pulse request, or a level raise that pends, raises `wake_o` one cycle after the pend shows, even for a disabled line, provided the lock was clear. A `force_wake` pulse raises `wake_o` two cycles later even under the lock.
- R13: An out-of-range index (at or above `LINES`) on a pulse request, a level event or an indexed command changes no state. It raises `err_o` for one cycle, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_pend_vld | input | 1 | Pulse pend request valid |
| hw_pend_idx | input | IDX_W | Line index of the pulse pend |
| lvl_vld | input | 1 | Level event valid |
| lvl_up | input | 1 | 1 = line raised, 0 = line lowered |
| lvl_idx | input | IDX_W | Line index of the level event |
| sw_op | input | 3 | Command: 0 none, 1 enable, 2 disable, 3 clear one, 4 clear all, 5 clear enabled, 6 re-evaluate |
| sw_idx | input | IDX_W | Line index for the indexed commands |
| lock_wr | input | 1 | Write the global lock |
| lock_val | input | 1 | New lock value |
| force_wake | input | 1 | Forced wake request that ignores the lock |
| level_o | output | LINES | Stored line levels |
| pend_o | output | LINES | Pending bits before the mask |
| mask_o | output | LINES | Enable mask |
| status_o | output | LINES | Pends seen while enabled |
| lock_o | output | 1 | Global lock |
| wake_o | output | 1 | CPU wake pulse |
| err_o | output | 1 | Out-of-range index seen |

## Verification
The assertions on disable and clear-all assume that no pulse request or level event arrives in the same cycle, because a same-cycle pend is applied after the command. Those assertions therefore take effect only when both peripheral inputs are idle. The stimulus table always drives one kind of request per cycle, so each row shows the effect of a single operation. The checks on the index range assume that inputs are idle during reset and in the two cycles that follow. The bench waits out the reset synchronizer before it drives anything.

// File: rtl/irq_pc_pkg.sv
package irq_pc_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_EN     = 3'd1,
    OP_DIS    = 3'd2,
    OP_CLR1   = 3'd3,
    OP_CLRALL = 3'd4,
    OP_CLREN  = 3'd5,
    OP_REEVAL = 3'd6
  } sw_op_e;
endpackage

// File: rtl/irq_idx_dec.sv
module irq_idx_dec #(
  parameter int LINES = 40,
  parameter int IDX_W = 6
) (
  input  logic             vld,
  input  logic [IDX_W-1:0] idx,
  output logic [LINES-1:0] oh,
  output logic             bad
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign oh[g] = vld && (idx == IDX_W'(g));
  end
  assign bad = vld && (32'(idx) >= LINES);
endmodule

// File: rtl/irq_line_state.sv
module irq_line_state
  import irq_pc_pkg::*;
#(
  parameter int LINES = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] hw_oh,
  input  logic [LINES-1:0] lvl_oh,
  input  logic             lvl_up,
  input  logic [LINES-1:0] sw_oh,
  input  sw_op_e           op,
  output logic [LINES-1:0] level_q,
  output logic [LINES-1:0] pre_q,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] st_q,
  output logic             rise_any,
  output logic             en_hit
);
  logic [LINES-1:0] lvl_n, pre_n, mask_n, st_n, rise, rev, set_v;
  logic             upd;

  always_comb begin
    lvl_n  = level_q;
    rise   = '0;
    mask_n = mask_q;
    pre_n  = pre_q;
    st_n   = st_q;
    rev    = '0;
    if (lvl_up) begin
      rise  = lvl_oh & ~level_q;
      lvl_n = level_q | lvl_oh;
    end else begin
      lvl_n = level_q & ~lvl_oh;
    end
    case (op)
      OP_EN: begin
        mask_n = mask_q | sw_oh;
        st_n   = st_q | (sw_oh & pre_q);
      end
      OP_DIS:    mask_n = mask_q & ~sw_oh;
      OP_CLR1: begin
        pre_n = pre_q & ~sw_oh;
        st_n  = st_q & ~sw_oh;
      end
      OP_CLRALL: begin
        pre_n = '0;
        st_n  = '0;
      end
      OP_CLREN: begin
        pre_n = pre_q & ~mask_q;
        st_n  = '0;
      end
      OP_REEVAL: rev = sw_oh & level_q;
      default: ;
    endcase
    // pends land after the commands of the same cycle
    set_v = hw_oh | rise | rev;
    pre_n = pre_n | set_v;
    st_n  = st_n | (set_v & mask_n);
  end

  assign upd      = (|hw_oh) || (|lvl_oh) || (op != OP_NONE);
  assign rise_any = |rise;
  assign en_hit   = (op == OP_EN) && (|(sw_oh & pre_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      pre_q   <= '0;
      mask_q  <= '0;
      st_q    <= '0;
    end else if (upd) begin
      level_q <= lvl_n;
      pre_q   <= pre_n;
      mask_q  <= mask_n;
      st_q    <= st_n;
    end
  end
endmodule

// File: rtl/irq_wake_seq.sv
module irq_wake_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_wr,
  input  logic lock_val,
  input  logic force_req,
  input  logic arm_hw,
  input  logic en_hit,
  input  logic st_any,
  output logic lock_q,
  output logic wake_q
);
  logic dly_q, frc_q;
  logic lock_n, dly_n, frc_n, wake_n, imm;

  always_comb begin
    lock_n = lock_wr ? lock_val : lock_q;
    imm    = (en_hit && !lock_q) ||
             (lock_q && lock_wr && !lock_val && st_any);
    dly_n  = (arm_hw && !lock_q) || force_req;
    frc_n  = force_req;
    wake_n = imm || (dly_q && (!lock_q || frc_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      dly_q  <= 1'b0;
      frc_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (lock_wr) lock_q <= lock_n;
      dly_q  <= dly_n;
      frc_q  <= frc_n;
      wake_q <= wake_n;
    end
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pc_pkg::*;
#(
  parameter int LINES = 40,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_pend_vld,
  input  logic [IDX_W-1:0] hw_pend_idx,
  input  logic             lvl_vld,
  input  logic             lvl_up,
  input  logic [IDX_W-1:0] lvl_idx,
  input  logic [2:0]       sw_op,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic             lock_wr,
  input  logic             lock_val,
  input  logic             force_wake,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] pend_o,
  output logic [LINES-1:0] mask_o,
  output logic [LINES-1:0] status_o,
  output logic             lock_o,
  output logic             wake_o,
  output logic             err_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  logic [LINES-1:0] hw_oh, lvl_oh, sw_oh;
  logic             bad_hw, bad_lvl, bad_sw, sw_indexed;
  logic             rise_any, en_hit, err_q;
  sw_op_e           op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign op = sw_op_e'(sw_op);
  assign sw_indexed = (op == OP_EN) || (op == OP_DIS) ||
                      (op == OP_CLR1) || (op == OP_REEVAL);

  irq_idx_dec #(.LINES(LINES), .IDX_W(IDX_W)) u_dec_hw (
    .vld(hw_pend_vld), .idx(hw_pend_idx), .oh(hw_oh), .bad(bad_hw));
  irq_idx_dec #(.LINES(LINES), .IDX_W(IDX_W)) u_dec_lvl (
    .vld(lvl_vld), .idx(lvl_idx), .oh(lvl_oh), .bad(bad_lvl));
  irq_idx_dec #(.LINES(LINES), .IDX_W(IDX_W)) u_dec_sw (
    .vld(sw_indexed), .idx(sw_idx), .oh(sw_oh), .bad(bad_sw));

  irq_line_state #(.LINES(LINES)) u_lines (
    .clk(clk), .rst_n(rst_i_n),
    .hw_oh(hw_oh), .lvl_oh(lvl_oh), .lvl_up(lvl_up),
    .sw_oh(sw_oh), .op(op),
    .level_q(level_o), .pre_q(pend_o), .mask_q(mask_o), .st_q(status_o),
    .rise_any(rise_any), .en_hit(en_hit));

  irq_wake_seq u_wake (
    .clk(clk), .rst_n(rst_i_n),
    .lock_wr(lock_wr), .lock_val(lock_val), .force_req(force_wake),
    .arm_hw((|hw_oh) || rise_any), .en_hit(en_hit), .st_any(|status_o),
    .lock_q(lock_o), .wake_q(wake_o));

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) err_q <= 1'b0;
    else          err_q <= bad_hw || bad_lvl || bad_sw;
  end
  assign err_o = err_q;
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
  parameter int LINES = 40,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_pend_vld,
  input logic [IDX_W-1:0] hw_pend_idx,
  input logic             lvl_vld,
  input logic             lvl_up,
  input logic [IDX_W-1:0] lvl_idx,
  input logic [2:0]       sw_op,
  input logic [IDX_W-1:0] sw_idx,
  input logic             lock_wr,
  input logic             lock_val,
  input logic             force_wake,
  input logic [LINES-1:0] level_o,
  input logic [LINES-1:0] pend_o,
  input logic [LINES-1:0] mask_o,
  input logic [LINES-1:0] status_o,
  input logic             lock_o,
  input logic             wake_o,
  input logic             err_o
);
  logic [LINES-1:0] hw_bit, lvl_bit, sw_bit;
  assign hw_bit  = LINES'(1) << hw_pend_idx;
  assign lvl_bit = LINES'(1) << lvl_idx;
  assign sw_bit  = LINES'(1) << sw_idx;

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_pend_vld && (32'(hw_pend_idx) < LINES) |=> |(pend_o & $past(hw_bit)));

  // R4
  dis_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_op == 3'd2) && !hw_pend_vld && !lvl_vld |=>
      (pend_o == $past(pend_o)) && (status_o == $past(status_o)) &&
      !(|(mask_o & $past(sw_bit))));

  // R5
  st_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~pend_o) == '0);

  // R7
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_op == 3'd4) && !hw_pend_vld && !lvl_vld |=>
      (pend_o == '0) && (status_o == '0));

  // R9
  lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_vld && !lvl_up && (32'(lvl_idx) < LINES) |=>
      !(|(level_o & $past(lvl_bit))));

  // R11
  unlock_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o && lock_wr && !lock_val && (|status_o) |=> wake_o);

  // R12
  force_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_wake |=> ##1 wake_o);

  // R13
  bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_vld && (32'(lvl_idx) >= LINES) |=> err_o);
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_irq_pend_ctrl.sv
`timescale 1ns/1ps
module tb_irq_pend_ctrl;
  localparam int LINES = 40;
  localparam int IDX_W = 6;
  localparam int NV    = 25;

  typedef struct packed {
    logic       hp;  logic [5:0] hi;
    logic       lv;  logic lu; logic [5:0] li;
    logic [2:0] op;  logic [5:0] si;
    logic       lw;  logic lval; logic fw;
    logic [7:0] ep;  logic [7:0] es; logic [7:0] em; logic [7:0] el;
    logic       ew;  logic ee; logic elk;
    logic [31:0] tag;
  } vec_t;

  // hp hi  lv lu li  op si  lw lv fw  pend  stat  mask  lvl  wk er lk tag
  localparam vec_t VEC [NV] = '{
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd1,6'd1,  1'b0,1'b0,1'b0, 8'h00,8'h00,8'h01<<1,8'h00, 1'b0,1'b0,1'b0, "R3"},
    '{1'b1,6'd0, 1'b0,1'b0,6'd0, 3'd0,6'd0,  1'b0,1'b0,1'b0, 8'h01,8'h00,8'h02,8'h00, 1'b0,1'b0,1'b0, "R2"},
    '{1'b1,6'd1, 1'b0,1'b0,6'd0, 3'd0,6'd0,  1'b0,1'b0,1'b0, 8'h03,8'h02,8'h02,8'h00, 1'b1,1'b0,1'b0, "R12"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd0,6'd0,  1'b0,1'b0,1'b0, 8'h03,8'h02,8'h02,8'h00, 1'b1,1'b0,1'b0, "R12"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd1,6'd0,  1'b0,1'b0,1'b0, 8'h03,8'h03,8'h03,8'h00, 1'b1,1'b0,1'b0, "R3"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd2,6'd1,  1'b0,1'b0,1'b0, 8'h03,8'h03,8'h01,8'h00, 1'b0,1'b0,1'b0, "R4"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd5,6'd0,  1'b0,1'b0,1'b0, 8'h02,8'h00,8'h01,8'h00, 1'b0,1'b0,1'b0, "R6"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd0,6'd0,  1'b1,1'b1,1'b0, 8'h02,8'h00,8'h01,8'h00, 1'b0,1'b0,1'b1, "R11"},
    '{1'b1,6'd0, 1'b0,1'b0,6'd0, 3'd0,6'd0,  1'b0,1'b0,1'b0, 8'h03,8'h01,8'h01,8'h00, 1'b0,1'b0,1'b1, "R11"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd0,6'd0,  1'b0,1'b0,1'b0, 8'h03,8'h01,8'h01,8'h00, 1'b0,1'b0,1'b1, "R11"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd0,6'd0,  1'b1,1'b0,1'b0, 8'h03,8'h01,8'h01,8'h00, 1'b1,1'b0,1'b0, "R11"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd3,6'd0,  1'b0,1'b0,1'b0, 8'h02,8'h00,8'h01,8'h00, 1'b0,1'b0,1'b0, "R5"},
    '{1'b0,6'd0, 1'b1,1'b1,6'd2, 3'd0,6'd0,  1'b0,1'b0,1'b0, 8'h06,8'h00,8'h01,8'h04, 1'b0,1'b0,1'b0, "R8"},
    '{1'b0,6'd0, 1'b1,1'b1,6'd2, 3'd0,6'd0,  1'b0,1'b0,1'b0, 8'h06,8'h00,8'h01,8'h04, 1'b1,1'b0,1'b0, "R12"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd3,6'd2,  1'b0,1'b0,1'b0, 8'h02,8'h00,8'h01,8'h04, 1'b0,1'b0,1'b0, "R8"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd6,6'd2,  1'b0,1'b0,1'b0, 8'h06,8'h00,8'h01,8'h04, 1'b0,1'b0,1'b0, "R10"},
    '{1'b0,6'd0, 1'b1,1'b0,6'd2, 3'd0,6'd0,  1'b0,1'b0,1'b0, 8'h06,8'h00,8'h01,8'h00, 1'b0,1'b0,1'b0, "R9"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd6,6'd2,  1'b0,1'b0,1'b0, 8'h06,8'h00,8'h01,8'h00, 1'b0,1'b0,1'b0, "R10"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd4,6'd0,  1'b0,1'b0,1'b0, 8'h00,8'h00,8'h01,8'h00, 1'b0,1'b0,1'b0, "R7"},
    '{1'b1,6'd45,1'b0,1'b0,6'd0, 3'd0,6'd0,  1'b0,1'b0,1'b0, 8'h00,8'h00,8'h01,8'h00, 1'b0,1'b1,1'b0, "R13"},
    '{1'b0,6'd0, 1'b1,1'b1,6'd63,3'd0,6'd0,  1'b0,1'b0,1'b0, 8'h00,8'h00,8'h01,8'h00, 1'b0,1'b1,1'b0, "R13"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd1,6'd50, 1'b0,1'b0,1'b0, 8'h00,8'h00,8'h01,8'h00, 1'b0,1'b1,1'b0, "R13"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd0,6'd0,  1'b1,1'b1,1'b1, 8'h00,8'h00,8'h01,8'h00, 1'b0,1'b0,1'b1, "R12"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd0,6'd0,  1'b0,1'b0,1'b0, 8'h00,8'h00,8'h01,8'h00, 1'b1,1'b0,1'b1, "R12"},
    '{1'b0,6'd0, 1'b0,1'b0,6'd0, 3'd0,6'd0,  1'b1,1'b0,1'b0, 8'h00,8'h00,8'h01,8'h00, 1'b0,1'b0,1'b0, "R11"}
  };

  logic             clk, rst_n;
  logic             hw_pend_vld, lvl_vld, lvl_up, lock_wr, lock_val, force_wake;
  logic [IDX_W-1:0] hw_pend_idx, lvl_idx, sw_idx;
  logic [2:0]       sw_op;
  logic [LINES-1:0] level_o, pend_o, mask_o, status_o;
  logic             lock_o, wake_o, err_o;
  int               n_tests, n_fail;
  logic             done;

  irq_pend_ctrl #(.LINES(LINES), .IDX_W(IDX_W)) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic drive(input vec_t v);
    hw_pend_vld = v.hp; hw_pend_idx = v.hi;
    lvl_vld = v.lv; lvl_up = v.lu; lvl_idx = v.li;
    sw_op = v.op; sw_idx = v.si;
    lock_wr = v.lw; lock_val = v.lval; force_wake = v.fw;
  endtask

  task automatic check_all(input string tag, input logic [7:0] ep, es, em, el,
                           input logic ew, ee, elk);
    logic [4*LINES+2:0] act, exp;
    act = {pend_o, status_o, mask_o, level_o, wake_o, err_o, lock_o};
    exp = {{32'h0, ep}, {32'h0, es}, {32'h0, em}, {32'h0, el}, ew, ee, elk};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pend/stat/mask/lvl/wake/err/lock actual=%h/%h/%h/%h/%b/%b/%b expected=%h/%h/%h/%h/%b/%b/%b",
               tag, pend_o, status_o, mask_o, level_o, wake_o, err_o, lock_o,
               ep, es, em, el, ew, ee, elk);
    end
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    drive('0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: state after reset
    check_all("R1", 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check_all($sformatf("%0s row%0d", VEC[i].tag, i), VEC[i].ep, VEC[i].es,
                VEC[i].em, VEC[i].el, VEC[i].ew, VEC[i].ee, VEC[i].elk);
    end

    // R2: pend on a disabled line under lock recorded, no status, no wake
    drive('0); lock_wr = 1'b1; lock_val = 1'b1;
    @(negedge clk);
    drive('0); hw_pend_vld = 1'b1; hw_pend_idx = 6'd39;
    @(negedge clk);
    drive('0);
    @(negedge clk);
    n_tests++;
    if (pend_o !== (LINES'(1) << 39) || status_o !== LINES'(0) || wake_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 top line pend=%h stat=%h wake=%b expected=%h/0/0",
               pend_o, status_o, wake_o, LINES'(1) << 39);
    end
    // R3: enable under lock moves pend to status but no wake
    sw_op = 3'd1; sw_idx = 6'd39;
    @(negedge clk);
    drive('0);
    n_tests++;
    if (status_o !== (LINES'(1) << 39) || wake_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R3 locked enable stat=%h wake=%b expected=%h/0",
               status_o, wake_o, LINES'(1) << 39);
    end

    // R1: asynchronous reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check_all("R1 midrun", 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 release", 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule